// File: doc/BRIEF.md
# Erased-Sector Zero-Bit Detector

This block decides whether a sector that the BCH decoder has marked uncorrectable is in fact a blank (erased) sector with only a few stray zero bits. It watches the sector stream as it goes to the decoder: 512 data bytes followed by 13 parity bytes, one byte per valid beat. For every byte it counts the bits that read as 0 and adds them into a small counter that stops at 9. At the beat marked last it issues a one-cycle verdict.

The verdict uses the decoder's error count, which is captured with the start pulse. A sector with 8 or fewer reported errors passes through unchanged. When the decoder reports more than 8 errors and the sector holds 8 or fewer zero bits in total, the sector is reported as erased with a corrected count of 0. A fill sweep then writes 0xFF into every data byte of the sector buffer. When the sector holds more than 8 zero bits, it is reported as an uncorrectable failure.

The fill sweep runs on its own. It can overlap the streaming and counting of the next sector.

Top module: `erased_sector_detector`

## Requirements
- R1: While reset is held and right after it is released, verdict_valid_o, verdict_erased_o, verdict_fail_o, fill_busy_o, fill_done_o and buf_we_o are all 0.
- R2: When the decoder count captured at start is 8 or less, the verdict has erased=0, fail=0 and verdict_err_o equal to the decoder count, whatever the sector holds, and no fill sweep starts.
- R3: When the decoder count is above 8, zero bits are counted over all 525 bytes, parity bytes included. If the total is 8 or less, the verdict has erased=1, fail=0 and verdict_err_o=0.
- R4: When the decoder count is above 8 and the total of zero bits exceeds 8, the verdict has fail=1, erased=0 and verdict_err_o equal to the decoder count.
- R5: The zero counter saturates at 9 and never wraps. A sector with 16 or more zero bits still gives a failure.
- R6: A beat with beat_valid_i low is not counted, whatever value sits on beat_data_i.
- R7: start_i clears the count and captures dec_err_i. A valid beat in the same cycle as start_i is counted as the first byte of the new sector.
- R8: verdict_valid_o goes high for exactly one cycle, in the cycle after the clock edge that samples the valid beat with beat_last_i high. Erased and fail are never both 1.
- R9: After an erased verdict, the block makes 512 consecutive buffer writes, starting in the next cycle, with data 0xFF and addresses 0 to 511 in ascending order. fill_busy_o is high during these writes. fill_done_o pulses for one cycle right after the last write.
- R10: A fill sweep runs to completion, unchanged, while the next sector is streamed, and that sector's verdict is still correct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Sector start pulse; clears the count and captures dec_err_i |
| dec_err_i | input | 4 | Error count reported by the decoder for this sector |
| beat_valid_i | input | 1 | beat_data_i holds a sector byte |
| beat_last_i | input | 1 | Marks the final byte of the sector (byte 525) |
| beat_data_i | input | 8 | Sector byte |
| verdict_valid_o | output | 1 | One-cycle verdict strobe |
| verdict_erased_o | output | 1 | Sector judged erased |
| verdict_fail_o | output | 1 | Sector judged uncorrectable |
| verdict_err_o | output | 4 | Corrected-error count to report |
| fill_busy_o | output | 1 | Fill sweep in progress |
| fill_done_o | output | 1 | One-cycle pulse at the end of a sweep |
| buf_we_o | output | 1 | Buffer write strobe |
| buf_addr_o | output | 9 | Buffer write address |
| buf_wdata_o | output | 8 | Buffer write data |

## Verification
Two functions can be active in the same cycle: the fill sweep left by an erased sector, and the counting of the next sector. The bench starts the next sector right after the erased verdict, so its first beat arrives together with the start pulse while writes are still in flight. It then checks three things: every write address in order, the buffer image after the sweep, and the failure verdict of the overlapping sector. That verdict depends on its first beat having been counted. A second case of the same kind inserts idle beats that carry zero-rich bytes, to confirm that only valid beats are counted.

// File: rtl/erz_pkg.sv
package erz_pkg;
  localparam int unsigned BYTE_W      = 8;
  localparam int unsigned DATA_BYTES  = 512;
  localparam int unsigned PAR_BYTES   = 13;
  localparam int unsigned ZERO_LIMIT  = 8;
  localparam int unsigned ERR_W       = 4;
  localparam int unsigned ZC_W        = $clog2(BYTE_W + 1);
  localparam int unsigned SAT_VAL     = ZERO_LIMIT + 1;
  localparam int unsigned CNT_W       = $clog2(SAT_VAL + 1);
  localparam int unsigned ADDR_W      = $clog2(DATA_BYTES);

  typedef struct packed {
    logic             valid;
    logic             erased;
    logic             fail;
    logic [ERR_W-1:0] err;
  } verdict_t;
endpackage

// File: rtl/erz_popcount.sv
module erz_popcount #(
  parameter int unsigned W   = 8,
  parameter int unsigned OUT_W = $clog2(W + 1)
) (
  input  logic [W-1:0]     byte_i,
  output logic [OUT_W-1:0] zeros_o
);
  logic [W-1:0] inv;

  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_inv
      assign inv[g] = ~byte_i[g];
    end
  endgenerate

  always_comb begin
    zeros_o = '0;
    for (int i = 0; i < W; i++) begin
      zeros_o = zeros_o + OUT_W'(inv[i]);
    end
  end

  always_comb begin
    assert (zeros_o <= OUT_W'(W)) else $error("assert_popcount_range_R3");
  end
endmodule

// File: rtl/erz_zero_counter.sv
module erz_zero_counter #(
  parameter int unsigned ADD_W = 4,
  parameter int unsigned SAT   = 9,
  parameter int unsigned CW    = $clog2(SAT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             add_en_i,
  input  logic [ADD_W-1:0] add_i,
  output logic [CW-1:0]    cnt_o,
  output logic [CW-1:0]    sum_o
);
  localparam int unsigned SUM_W = ((CW > ADD_W) ? CW : ADD_W) + 1;

  logic [CW-1:0]    cnt_q, cnt_d;
  logic             cnt_en;
  logic [SUM_W-1:0] base, inc, raw;

  always_comb begin
    base  = clr_i ? '0 : SUM_W'(cnt_q);
    inc   = add_en_i ? SUM_W'(add_i) : '0;
    raw   = base + inc;
    sum_o = (raw > SUM_W'(SAT)) ? CW'(SAT) : raw[CW-1:0];
    cnt_en = clr_i | add_en_i;
    cnt_d  = sum_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

  assert_no_overflow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(SAT));

  assert_idle_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!add_en_i && !clr_i) |=> $stable(cnt_q));

  assert_sat_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CW'(SAT) && !clr_i) |=> cnt_q == CW'(SAT));
endmodule

// File: rtl/erz_fill_engine.sv
module erz_fill_engine #(
  parameter int unsigned DEPTH    = 512,
  parameter int unsigned DW       = 8,
  parameter logic [DW-1:0] FILL_VAL = '1,
  parameter int unsigned AW       = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o
);
  localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

  logic          busy_q, busy_d;
  logic [AW-1:0] addr_q, addr_d;
  logic          done_q, done_d;
  logic          at_end;

  always_comb begin
    at_end = busy_q && (addr_q == LAST_ADDR);
    busy_d = busy_q;
    addr_d = addr_q;
    done_d = 1'b0;
    if (go_i) begin
      busy_d = 1'b1;
      addr_d = '0;
    end else if (at_end) begin
      busy_d = 1'b0;
      addr_d = '0;
      done_d = 1'b1;
    end else if (busy_q) begin
      addr_d = addr_q + AW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      addr_q <= '0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      addr_q <= addr_d;
      done_q <= done_d;
    end
  end

  assign busy_o  = busy_q;
  assign done_o  = done_q;
  assign we_o    = busy_q;
  assign addr_o  = addr_q;
  assign wdata_o = FILL_VAL;

  assert_addr_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !go_i && !at_end) |=> (busy_q && addr_q == $past(addr_q) + AW'(1)));

  assert_done_after_last_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> ($past(busy_q) && $past(addr_q) == LAST_ADDR && !busy_q));

  assert_go_starts_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_i |=> (busy_q && addr_q == '0));
endmodule

// File: rtl/erased_sector_detector.sv
module erased_sector_detector
  import erz_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ERR_W-1:0]  dec_err_i,
  input  logic              beat_valid_i,
  input  logic              beat_last_i,
  input  logic [BYTE_W-1:0] beat_data_i,
  output logic              verdict_valid_o,
  output logic              verdict_erased_o,
  output logic              verdict_fail_o,
  output logic [ERR_W-1:0]  verdict_err_o,
  output logic              fill_busy_o,
  output logic              fill_done_o,
  output logic              buf_we_o,
  output logic [ADDR_W-1:0] buf_addr_o,
  output logic [BYTE_W-1:0] buf_wdata_o
);
  logic [ZC_W-1:0]  byte_zeros;
  logic [CNT_W-1:0] zcnt, zsum;
  logic [ERR_W-1:0] err_q, err_d, err_src;
  logic             last_fire, flagged, clean;
  verdict_t         vd_q, vd_d;

  erz_popcount #(.W(BYTE_W), .OUT_W(ZC_W)) u_pop (
    .byte_i  (beat_data_i),
    .zeros_o (byte_zeros)
  );

  erz_zero_counter #(.ADD_W(ZC_W), .SAT(SAT_VAL), .CW(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (start_i),
    .add_en_i (beat_valid_i),
    .add_i    (byte_zeros),
    .cnt_o    (zcnt),
    .sum_o    (zsum)
  );

  always_comb begin
    err_d     = start_i ? dec_err_i : err_q;
    err_src   = err_d;
    last_fire = beat_valid_i && beat_last_i;
    flagged   = err_src > ERR_W'(ZERO_LIMIT);
    clean     = zsum <= CNT_W'(ZERO_LIMIT);
    vd_d.valid  = last_fire;
    vd_d.erased = last_fire && flagged && clean;
    vd_d.fail   = last_fire && flagged && !clean;
    if (!last_fire || vd_d.erased) vd_d.err = '0;
    else                           vd_d.err = err_src;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q <= '0;
    end else if (start_i) begin
      err_q <= err_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vd_q <= '0;
    end else begin
      vd_q <= vd_d;
    end
  end

  assign verdict_valid_o  = vd_q.valid;
  assign verdict_erased_o = vd_q.erased;
  assign verdict_fail_o   = vd_q.fail;
  assign verdict_err_o    = vd_q.err;

  erz_fill_engine #(.DEPTH(DATA_BYTES), .DW(BYTE_W), .FILL_VAL('1), .AW(ADDR_W)) u_fill (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .go_i    (vd_q.erased),
    .busy_o  (fill_busy_o),
    .done_o  (fill_done_o),
    .we_o    (buf_we_o),
    .addr_o  (buf_addr_o),
    .wdata_o (buf_wdata_o)
  );

  assert_verdict_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(verdict_erased_o && verdict_fail_o));

  assert_flags_need_valid_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !verdict_valid_o |-> (!verdict_erased_o && !verdict_fail_o));

  assert_erased_zero_count_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    verdict_erased_o |-> (verdict_err_o == '0));

  assert_fill_follows_erased_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    verdict_erased_o |=> (fill_busy_o && buf_we_o && buf_addr_o == '0));

  assert_passthrough_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (verdict_valid_o && verdict_err_o != '0 && verdict_err_o <= ERR_W'(ZERO_LIMIT))
      |-> (!verdict_erased_o && !verdict_fail_o));
endmodule

// File: tb/tb_erased_sector_detector.sv
module tb_erased_sector_detector;
  localparam int NB = 525;
  localparam int ND = 512;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       start_i;
  logic [3:0] dec_err_i;
  logic       beat_valid_i, beat_last_i;
  logic [7:0] beat_data_i;
  logic       verdict_valid_o, verdict_erased_o, verdict_fail_o;
  logic [3:0] verdict_err_o;
  logic       fill_busy_o, fill_done_o, buf_we_o;
  logic [8:0] buf_addr_o;
  logic [7:0] buf_wdata_o;

  erased_sector_detector dut (.*);

  always #2.5 clk_i = ~clk_i;

  int errors = 0;
  int checks = 0;
  logic [7:0] sec [NB];
  logic [7:0] mem [ND];
  int wr_cnt = 0;
  int exp_addr = 0;
  int mon_bad = 0;
  int done_seen = 0;
  int done_at_wr = -1;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  always @(negedge clk_i) begin
    if (rst_ni && buf_we_o) begin
      if (buf_wdata_o !== 8'hFF || int'(buf_addr_o) != exp_addr) mon_bad++;
      mem[buf_addr_o] = buf_wdata_o;
      exp_addr++;
      wr_cnt++;
    end
    if (rst_ni && fill_done_o) begin
      done_seen++;
      done_at_wr = wr_cnt;
    end
  end

  function automatic int zeros_in_sector();
    int z = 0;
    for (int i = 0; i < NB; i++)
      for (int b = 0; b < 8; b++) z += (sec[i][b] == 1'b0) ? 1 : 0;
    return z;
  endfunction

  task automatic blank_sector();
    for (int i = 0; i < NB; i++) sec[i] = 8'hFF;
  endtask

  task automatic scatter_zeros(input int n);
    for (int k = 0; k < n; k++) sec[(k * 61) % NB][k % 8] = 1'b0;
  endtask

  task automatic clear_mem();
    for (int i = 0; i < ND; i++) mem[i] = 8'h00;
    exp_addr = 0; wr_cnt = 0; mon_bad = 0; done_seen = 0; done_at_wr = -1;
  endtask

  // Streams sec[]; on return the verdict of the sector is on the outputs.
  task automatic stream(input int err, input bit start_with_beat, input bit gaps);
    if (!start_with_beat) begin
      start_i = 1'b1; dec_err_i = 4'(err); beat_valid_i = 1'b0;
      @(posedge clk_i); #1;
      start_i = 1'b0;
    end
    for (int i = 0; i < NB; i++) begin
      if (gaps && (i % 40 == 5)) begin
        beat_valid_i = 1'b0; beat_last_i = 1'b0; beat_data_i = 8'h00;
        @(posedge clk_i); #1;
      end
      start_i      = start_with_beat && (i == 0);
      dec_err_i    = 4'(err);
      beat_valid_i = 1'b1;
      beat_last_i  = (i == NB - 1);
      beat_data_i  = sec[i];
      @(posedge clk_i); #1;
      start_i = 1'b0;
    end
    beat_valid_i = 1'b0; beat_last_i = 1'b0; beat_data_i = 8'h00;
  endtask

  task automatic judge(input int err, input string rq);
    int z = zeros_in_sector();
    bit ex_er = (err > 8) && (z <= 8);
    bit ex_fl = (err > 8) && (z > 8);
    int ex_c  = ex_er ? 0 : err;
    chk(verdict_valid_o === 1'b1, {rq, " R8 verdict strobe"}, verdict_valid_o, 1);
    chk(verdict_erased_o === ex_er, {rq, " erased flag"}, verdict_erased_o, ex_er);
    chk(verdict_fail_o === ex_fl, {rq, " fail flag"}, verdict_fail_o, ex_fl);
    chk(int'(verdict_err_o) == ex_c, {rq, " reported count"}, verdict_err_o, ex_c);
  endtask

  task automatic strobe_drops();
    @(posedge clk_i); #1;
    chk(verdict_valid_o === 1'b0, "R8 strobe one cycle", verdict_valid_o, 0);
  endtask

  task automatic wait_fill(input string rq);
    for (int c = 0; c < 700 && done_seen == 0; c++) begin
      @(posedge clk_i); #1;
    end
    chk(wr_cnt == ND, {rq, " write count"}, wr_cnt, ND);
    chk(mon_bad == 0, {rq, " address/data sequence"}, mon_bad, 0);
    chk(done_seen == 1 && done_at_wr == ND, {rq, " done after last write"}, done_at_wr, ND);
    begin
      int bad = 0;
      for (int i = 0; i < ND; i++) if (mem[i] !== 8'hFF) bad++;
      chk(bad == 0, {rq, " buffer all 0xFF"}, bad, 0);
    end
    chk(fill_busy_o === 1'b0, {rq, " busy drops"}, fill_busy_o, 0);
  endtask

  task automatic no_fill(input string rq);
    repeat (20) @(posedge clk_i);
    #1;
    chk(wr_cnt == 0 && fill_busy_o === 1'b0, {rq, " no fill"}, wr_cnt, 0);
  endtask

  task automatic t_reset();
    chk(verdict_valid_o === 1'b0 && verdict_erased_o === 1'b0 && verdict_fail_o === 1'b0,
        "R1 verdict idle", verdict_valid_o, 0);
    chk(fill_busy_o === 1'b0 && fill_done_o === 1'b0 && buf_we_o === 1'b0,
        "R1 fill idle", buf_we_o, 0);
  endtask

  task automatic t_passthrough();
    clear_mem(); blank_sector(); scatter_zeros(30);
    stream(5, 1'b0, 1'b0); judge(5, "R2 low decoder count"); strobe_drops();
    no_fill("R2");
  endtask

  task automatic t_blank_erased();
    clear_mem(); blank_sector();
    stream(12, 1'b0, 1'b0); judge(12, "R3 blank sector");
    wait_fill("R9");
  endtask

  task automatic t_eight_with_parity();
    clear_mem(); blank_sector(); scatter_zeros(5);
    sec[515] = 8'hF8;
    stream(10, 1'b0, 1'b0); judge(10, "R3 eight zeros incl parity");
    wait_fill("R9 second sweep");
  endtask

  task automatic t_nine_fail();
    clear_mem(); blank_sector(); scatter_zeros(8);
    sec[524][7] = 1'b0;
    stream(13, 1'b0, 1'b0); judge(13, "R4 nine zeros, last parity byte");
    no_fill("R4");
  endtask

  task automatic t_saturate();
    clear_mem(); blank_sector();
    sec[100] = 8'h00; sec[200] = 8'h00;
    stream(15, 1'b0, 1'b0); judge(15, "R5 sixteen zeros no wrap");
    no_fill("R5");
  endtask

  task automatic t_gaps();
    clear_mem(); blank_sector(); scatter_zeros(3);
    stream(9, 1'b0, 1'b1); judge(9, "R6 idle zero bytes ignored");
    wait_fill("R6 sweep");
  endtask

  task automatic t_overlap();
    clear_mem(); blank_sector();
    stream(11, 1'b0, 1'b0); judge(11, "R10 first sector");
    blank_sector(); sec[0] = 8'h00; sec[1] = 8'hFE;
    stream(11, 1'b1, 1'b0); judge(11, "R7 R10 start with beat, overlapped");
    wait_fill("R10 overlapped sweep");
  endtask

  initial begin
    rst_ni = 1'b0; start_i = 1'b0; dec_err_i = '0;
    beat_valid_i = 1'b0; beat_last_i = 1'b0; beat_data_i = '0;
    repeat (3) @(posedge clk_i);
    #1;
    t_reset();
    rst_ni = 1'b1;
    @(posedge clk_i); #1;
    t_reset();
    t_passthrough();
    t_blank_erased();
    t_eight_with_parity();
    t_nine_fail();
    t_saturate();
    t_gaps();
    t_overlap();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule